// File: doc/BRIEF.md
# Incremental Line Drawing Stepper

This block walks a straight line one pixel at a time using integer error-term arithmetic. Before starting, software places on the inputs the start position, a length count, the initial error term and two signed step constants: the axial constant (twice the minor-axis delta) and the diagonal constant (twice the minor-axis delta minus twice the major-axis delta). The initial error term is twice the minor-axis delta minus the major-axis delta, minus any fixup the caller chooses. A three-bit direction field picks the major axis and the direction of travel on each axis.

A single-cycle start pulse loads these values. The block then presents one coordinate at a time on a valid/ready output. Each accepted pixel moves the live position by one step, and the live position is visible on the current-position outputs. After the last pixel is accepted the block returns to idle and pulses done. Working out the constants from endpoints, clipping, colour mixing and frame-buffer writes are left to other logic.

Top module: `line_stepper`

## Requirements
- R1: While reset is asserted and just after it is released, `busy`, `done` and `px_valid` are low.
- R2: A `start` pulse seen while idle loads the start position, and the first pixel offered equals (`x_init`, `y_init`).
- R3: The length count is 0-based. A count of N produces exactly N+1 accepted pixels, so a count of 0 produces one pixel.
- R4: At each step the error term is read as a signed 16-bit value. If it is negative, `k_axial` is added and only the major axis moves. Otherwise `k_diag` is added and both axes move.
- R5: `dir[0]` selects the major axis (0 = X, 1 = Y). `dir[1]`=1 makes X step by -1 (else +1). `dir[2]`=1 makes Y step by -1 (else +1).
- R6: Coordinates wrap modulo 2^16. Stepping down from 0 gives 65535.
- R7: While `px_valid` is high and `px_ready` is low, the offered pixel holds still and stays valid. The position advances only when a pixel is accepted.
- R8: `cur_x`/`cur_y` follow the live point. After the line ends they hold the last pixel drawn.
- R9: `done` is high for exactly one cycle, in the cycle after the last pixel is accepted, and `busy` is low in that cycle.
- R10: A `start` pulse while busy is ignored. The line in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a line (honoured only when idle) |
| dir | input | 3 | Major-axis select and axis direction bits |
| x_init | input | 16 | Start X coordinate |
| y_init | input | 16 | Start Y coordinate |
| k_axial | input | 16 | Signed constant added on an axial step |
| k_diag | input | 16 | Signed constant added on a diagonal step |
| err_init | input | 16 | Signed initial error term |
| len_init | input | 16 | 0-based pixel count |
| px_valid | output | 1 | A pixel coordinate is offered |
| px_ready | input | 1 | Consumer takes the offered pixel |
| px_x | output | 16 | Offered pixel X |
| px_y | output | 16 | Offered pixel Y |
| cur_x | output | 16 | Live current-position X |
| cur_y | output | 16 | Live current-position Y |
| busy | output | 1 | A line is in progress |
| done | output | 1 | One-cycle end-of-line pulse |

## Verification
The bench targets a zero-length line. A design with an off-by-one length would emit two pixels there, or none. It runs an X-major and a Y-major line whose error term crosses zero in both directions. A sign test on the wrong bit, or swapped constants, would step diagonally in the wrong places. A line that decrements from the origin would expose missing wrap-around. A stalled consumer and a stray `start` in mid-line would catch a design that skips pixels under backpressure or restarts itself, and the bench also checks that `done` lasts one cycle, no more.

// File: rtl/line_pkg.sv
package line_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } line_state_e;

  localparam int unsigned AXIS_X = 0;
  localparam int unsigned AXIS_Y = 1;
  localparam int unsigned N_AXES = 2;
endpackage

// File: rtl/line_err_unit.sv
module line_err_unit #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] err_init,
  input  logic [W-1:0] k_axial,
  input  logic [W-1:0] k_diag,
  output logic         diag
);
  logic [W-1:0] err_q, err_d;
  logic [W-1:0] k1_q, k1_d, k2_q, k2_d;

  // sign bit clear means error term >= 0 -> diagonal step
  assign diag = ~err_q[W-1];

  always_comb begin
    err_d = err_q;
    k1_d  = k1_q;
    k2_d  = k2_q;
    if (load) begin
      err_d = err_init;
      k1_d  = k_axial;
      k2_d  = k_diag;
    end else if (step) begin
      err_d = err_q + (diag ? k2_q : k1_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      k1_q  <= '0;
      k2_q  <= '0;
    end else if (load || step) begin
      err_q <= err_d;
      k1_q  <= k1_d;
      k2_q  <= k2_d;
    end
  end
endmodule

// File: rtl/line_axis.sv
module line_axis #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] init,
  input  logic         move,
  input  logic         down,
  output logic [W-1:0] pos
);
  logic [W-1:0] pos_d;
  logic         dir_q, dir_d;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    pos_d = pos;
    dir_d = dir_q;
    if (load) begin
      pos_d = init;
      dir_d = down;
    end else if (move) begin
      pos_d = dir_q ? (pos - ONE) : (pos + ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= '0;
      dir_q <= 1'b0;
    end else if (load || move) begin
      pos   <= pos_d;
      dir_q <= dir_d;
    end
  end
endmodule

// File: rtl/line_len_ctr.sv
module line_len_ctr #(
  parameter int unsigned LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] len_init,
  input  logic          dec,
  output logic          last
);
  logic [LW-1:0] cnt_q, cnt_d;

  assign last = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = len_init;
    else if (dec) cnt_d = cnt_q - {{(LW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load || dec) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/line_stepper.sv
module line_stepper
  import line_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    dir,
  input  logic [W-1:0]  x_init,
  input  logic [W-1:0]  y_init,
  input  logic [W-1:0]  k_axial,
  input  logic [W-1:0]  k_diag,
  input  logic [W-1:0]  err_init,
  input  logic [LW-1:0] len_init,
  output logic          px_valid,
  input  logic          px_ready,
  output logic [W-1:0]  px_x,
  output logic [W-1:0]  px_y,
  output logic [W-1:0]  cur_x,
  output logic [W-1:0]  cur_y,
  output logic          busy,
  output logic          done
);
  line_state_e state_q, state_d;
  logic        done_d;
  logic        major_y_q, major_y_d;
  logic        load, accept, last, advance, diag;

  logic [W-1:0] ax_init [N_AXES];
  logic [W-1:0] ax_pos  [N_AXES];
  logic         ax_move [N_AXES];
  logic         ax_down [N_AXES];

  assign busy     = (state_q == ST_RUN);
  assign px_valid = busy;
  assign load     = start && (state_q == ST_IDLE);
  assign accept   = px_valid && px_ready;
  assign advance  = accept && !last;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    major_y_d = major_y_q;
    done_d    = 1'b0;
    case (state_q)
      ST_IDLE: if (load) begin
        state_d   = ST_RUN;
        major_y_d = dir[0];
      end
      ST_RUN: if (accept && last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      major_y_q <= 1'b0;
      done      <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
      if (load) major_y_q <= major_y_d;
    end
  end

  assign ax_init[AXIS_X] = x_init;
  assign ax_init[AXIS_Y] = y_init;
  assign ax_down[AXIS_X] = dir[1];
  assign ax_down[AXIS_Y] = dir[2];
  assign ax_move[AXIS_X] = advance && (diag || !major_y_q);
  assign ax_move[AXIS_Y] = advance && (diag ||  major_y_q);

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    line_axis #(.W(W)) u_axis (
      .clk  (clk),
      .rst_n(rst_n),
      .load (load),
      .init (ax_init[a]),
      .move (ax_move[a]),
      .down (ax_down[a]),
      .pos  (ax_pos[a])
    );
  end

  line_err_unit #(.W(W)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (advance),
    .err_init(err_init),
    .k_axial (k_axial),
    .k_diag  (k_diag),
    .diag    (diag)
  );

  line_len_ctr #(.LW(LW)) u_len (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .len_init(len_init),
    .dec     (advance),
    .last    (last)
  );

  assign cur_x = ax_pos[AXIS_X];
  assign cur_y = ax_pos[AXIS_Y];
  assign px_x  = cur_x;
  assign px_y  = cur_y;
endmodule

// File: rtl/line_stepper_chk.sv
module line_stepper_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] x_init,
  input logic [W-1:0] y_init,
  input logic         px_valid,
  input logic         px_ready,
  input logic [W-1:0] px_x,
  input logic [W-1:0] px_y,
  input logic [W-1:0] cur_x,
  input logic [W-1:0] cur_y,
  input logic         busy,
  input logic         done
);
  // R7: a stalled pixel stays valid and unchanged
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |=> (px_valid && $stable(px_x) && $stable(px_y)));

  // R9: done is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: block is idle while done is shown
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2: a new line begins at the loaded start point
  assert_load_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start) && cur_x == $past(x_init) && cur_y == $past(y_init)));

  // R10: a start while busy without a handshake leaves the position alone
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(px_valid && px_ready)) |=> ($stable(cur_x) && $stable(cur_y) && busy));
endmodule

bind line_stepper line_stepper_chk #(.W(W)) u_line_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .x_init  (x_init),
  .y_init  (y_init),
  .px_valid(px_valid),
  .px_ready(px_ready),
  .px_x    (px_x),
  .px_y    (px_y),
  .cur_x   (cur_x),
  .cur_y   (cur_y),
  .busy    (busy),
  .done    (done)
);

// File: tb/line_stepper_tb_top.sv
module line_stepper_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] x0;
    logic [15:0] y0;
    logic [15:0] k1;
    logic [15:0] k2;
    logic [15:0] e0;
    logic [15:0] len;
    logic [2:0]  dr;
    logic [15:0] fx;
    logic [15:0] fy;
  } vec_t;

  // fx/fy: expected final pixel worked out by hand from R4/R5/R6
  localparam vec_t VECS [4] = '{
    '{16'd10,  16'd20, 16'd4, 16'hFFFA, 16'hFFFF, 16'd5, 3'b000, 16'd15,    16'd22},
    '{16'd100, 16'd50, 16'd4, 16'hFFF8, 16'hFFFE, 16'd6, 3'b011, 16'd98,    16'd56},
    '{16'd7,   16'd9,  16'd4, 16'hFFF8, 16'h0001, 16'd0, 3'b000, 16'd7,     16'd9},
    '{16'd0,   16'd0,  16'd6, 16'h0000, 16'h0003, 16'd3, 3'b110, 16'd65533, 16'd65533}
  };

  logic        clk, rst_n, start, px_ready;
  logic [2:0]  dir;
  logic [15:0] x_init, y_init, k_axial, k_diag, err_init, len_init;
  logic        px_valid, busy, done;
  logic [15:0] px_x, px_y, cur_x, cur_y;

  int n_chk;
  int n_bad;

  line_stepper dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dir(dir),
    .x_init(x_init), .y_init(y_init), .k_axial(k_axial), .k_diag(k_diag),
    .err_init(err_init), .len_init(len_init),
    .px_valid(px_valid), .px_ready(px_ready), .px_x(px_x), .px_y(px_y),
    .cur_x(cur_x), .cur_y(cur_y), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Run one line; stall_mod>0 drops ready every stall_mod cycles;
  // poke>0 pulses start with garbage inputs at that cycle
  task automatic run_line(input vec_t v, input int stall_mod, input int poke);
    logic [15:0] mx, my, e;
    int pix;
    int cyc;
    @(negedge clk);
    x_init = v.x0; y_init = v.y0; k_axial = v.k1; k_diag = v.k2;
    err_init = v.e0; len_init = v.len; dir = v.dr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mx = v.x0; my = v.y0; e = v.e0; pix = 0; cyc = 0;
    check("R2 busy after start", busy, 1);
    while (busy && cyc < 1000) begin
      px_ready = !(stall_mod > 0 && (cyc % stall_mod) == 1);
      if (poke > 0 && cyc == poke) begin
        start = 1'b1; x_init = 16'd999; y_init = 16'd999; len_init = 16'd0;
      end else begin
        start = 1'b0;
      end
      #1;
      if (px_valid && px_ready) begin
        check("R4 R5 R6 pixel x", px_x, mx);
        check("R4 R5 R6 pixel y", px_y, my);
        pix++;
        if (pix <= v.len) begin
          if (!e[15]) begin
            e = e + v.k2;
            mx = v.dr[1] ? mx - 16'd1 : mx + 16'd1;
            my = v.dr[2] ? my - 16'd1 : my + 16'd1;
          end else begin
            e = e + v.k1;
            if (v.dr[0]) my = v.dr[2] ? my - 16'd1 : my + 16'd1;
            else         mx = v.dr[1] ? mx - 16'd1 : mx + 16'd1;
          end
        end
      end
      @(negedge clk);
      cyc++;
      if (!busy) check("R9 done after last pixel", done, 1);
    end
    start = 1'b0;
    px_ready = 1'b1;
    check("R3 pixel count", pix, 32'(v.len) + 1);
    check("R10 no restart (count)", pix, 32'(v.len) + 1);
    check("R8 final cur_x", cur_x, v.fx);
    check("R8 final cur_y", cur_y, v.fy);
    check("R9 busy low with done", busy, 0);
    @(negedge clk);
    check("R9 done one cycle", done, 0);
    check("R8 position held", cur_x, v.fx);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; start = 1'b0; px_ready = 1'b1; dir = 3'b0;
    x_init = '0; y_init = '0; k_axial = '0; k_diag = '0; err_init = '0; len_init = '0;
    #(CLK_PERIOD*3 + 2);
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    check("R1 valid in reset", px_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", px_valid, 0);

    for (int i = 0; i < 4; i++) run_line(VECS[i], 0, 0);

    // R7 backpressure on the Y-major line
    run_line(VECS[1], 3, 0);
    // R10 start pulse in mid-line is ignored
    run_line(VECS[0], 0, 2);
    // R3 single pixel under a stall
    run_line(VECS[2], 2, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule